// File: doc/BRIEF.md
# Bus Cycle Status Decoder

This block sits beside a processor that reports each bus transfer on a three-bit status bus. It follows that bus one clock at a time, together with a tag that names the current clock state (T1, T2, T3, Tw, T4 or idle), a READY input and a flag that is high while another master holds the bus. From these it works out when a transfer begins and when it ends. It then drives a one-clock address-latch pulse, one command strobe per transfer kind, and a registered copy of the transfer code.

A transfer begins when the status moves off the all-ones idle code in a state where a new transfer may open. It ends when the status comes back to all-ones in T3, or in a wait state once READY is high. While the bus is granted away, the status lines float high. The decoder forces the status to idle whenever the grant flag is up, so a floating bus never opens a transfer. All outputs come from registers and change on the clock edge after the event that causes them.

The interface is made up of plain control and status pins only. No data payload passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `bus_cycle_decoder`

## Requirements
- R1: The status codes are 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write and 111 idle. `cyc_code` shows the code of the open transfer, and shows 111 while no transfer is open.
- R2: The clock states are encoded on `phase` as T1=0, T2=1, T3=2, Tw=3, T4=4 and idle=5. A transfer opens on an edge where no transfer is open, the status sampled on the previous edge was 111, the status now differs from 111, and `phase` is T4 or T1. From the next clock, the matching strobe is high and `cyc_code` holds that code.
- R3: `ale` is high for exactly the one clock that follows the edge where a transfer opens, and is low otherwise.
- R4: An open transfer closes on an edge where the status is 111 and `phase` is T3, or where the status is 111, `phase` is Tw and `rdy` is 1. From the next clock, all strobes are low. In Tw with `rdy` at 0 the transfer stays open.
- R5: While a transfer is open, status 111 in T1, T2 or T4 does not close it, and a different non-idle code does not change `cyc_code`.
- R6: Status leaving 111 while `phase` is T2, T3, Tw or idle does not open a transfer.
- R7: While `grant_act` is 1, the status reads as 111. No transfer opens, `ale` stays low, and a transfer that is open is dropped on that edge.
- R8: At most one strobe is high at a time. Status 011 raises only `halt_ind` and no read or write strobe.
- R9: With `rst` high at an edge, all strobes and `ale` are low after that edge and `cyc_code` is 111. The status sampled before the next edge counts as 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_in | input | 3 | Processor status code |
| phase | input | 3 | Current clock state tag |
| rdy | input | 1 | READY; ends a wait state |
| grant_act | input | 1 | Bus granted to another master |
| ale | output | 1 | One-clock address-latch pulse |
| int_ack | output | 1 | Interrupt acknowledge strobe |
| rd_io | output | 1 | I/O read strobe |
| wr_io | output | 1 | I/O write strobe |
| halt_ind | output | 1 | Halt indication |
| fetch | output | 1 | Code fetch strobe |
| rd_mem | output | 1 | Memory read strobe |
| wr_mem | output | 1 | Memory write strobe |
| cyc_code | output | 3 | Code of the open transfer, 111 when none |

## Verification
The hardest case to reach is a status change that the decoder must refuse to treat as an edge. This happens in two ways: the status leaves 111 in the wrong clock state, or the grant flag falls while the status is already non-idle. The stimulus first moves the status off idle during T2 and holds it there. It then checks that a later T4 opens nothing, because the previous sample was not 111. Separately, the bench raises the grant with a non-idle code present, lowers it, and confirms that the masked idle sample lets the next T4 open a transfer cleanly. It also checks that a grant raised in mid-transfer drops the strobe at once.

// File: rtl/bcsd_pkg.sv
package bcsd_pkg;
  localparam int ST_W  = 3;
  localparam int PH_W  = 3;
  localparam int N_CMD = (1 << ST_W) - 1;

  typedef logic [ST_W-1:0] st_t;

  localparam st_t ST_IDLE = '1;
  localparam st_t ST_INTA = 3'd0;
  localparam st_t ST_IORD = 3'd1;
  localparam st_t ST_IOWR = 3'd2;
  localparam st_t ST_HALT = 3'd3;
  localparam st_t ST_CODE = 3'd4;
  localparam st_t ST_MRD  = 3'd5;
  localparam st_t ST_MWR  = 3'd6;

  typedef enum logic [PH_W-1:0] {
    PH_T1 = 3'd0,
    PH_T2 = 3'd1,
    PH_T3 = 3'd2,
    PH_TW = 3'd3,
    PH_T4 = 3'd4,
    PH_TI = 3'd5
  } phase_e;
endpackage

// File: rtl/bcsd_status_sampler.sv
module bcsd_status_sampler #(
  parameter int ST_W = bcsd_pkg::ST_W,
  parameter int PH_W = bcsd_pkg::PH_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] st_in,
  input  logic [PH_W-1:0] phase,
  input  logic            rdy,
  input  logic            grant_act,
  output logic [ST_W-1:0] st_eff,
  output logic            leave_idle,
  output logic            back_idle
);
  localparam logic [ST_W-1:0] IDLE = '1;
  localparam logic [PH_W-1:0] P_T1 = PH_W'(bcsd_pkg::PH_T1);
  localparam logic [PH_W-1:0] P_T3 = PH_W'(bcsd_pkg::PH_T3);
  localparam logic [PH_W-1:0] P_TW = PH_W'(bcsd_pkg::PH_TW);
  localparam logic [PH_W-1:0] P_T4 = PH_W'(bcsd_pkg::PH_T4);

  logic [ST_W-1:0] prev_q;
  logic            open_slot;
  logic            close_slot;

  // a floating bus during grant reads as idle
  assign st_eff = grant_act ? IDLE : st_in;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE;
    else     prev_q <= st_eff;
  end

  assign open_slot  = (phase == P_T4) || (phase == P_T1);
  assign close_slot = (phase == P_T3) || ((phase == P_TW) && rdy);

  assign leave_idle = (prev_q == IDLE) && (st_eff != IDLE) && open_slot;
  assign back_idle  = (st_eff == IDLE) && close_slot;
endmodule

// File: rtl/bcsd_cycle_tracker.sv
module bcsd_cycle_tracker #(
  parameter int ST_W = bcsd_pkg::ST_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            grant_act,
  input  logic [ST_W-1:0] st_eff,
  input  logic            leave_idle,
  input  logic            back_idle,
  output logic            busy_q,
  output logic [ST_W-1:0] code_q,
  output logic            ale_q
);
  localparam logic [ST_W-1:0] IDLE = '1;

  typedef enum logic { TRK_IDLE, TRK_BUSY } trk_e;

  trk_e state_q, state_d;
  logic [ST_W-1:0] code_d;
  logic            start_p;

  assign start_p = (state_q == TRK_IDLE) && leave_idle && !grant_act;

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    if (grant_act) begin
      state_d = TRK_IDLE;
      code_d  = IDLE;
    end else if (start_p) begin
      state_d = TRK_BUSY;
      code_d  = st_eff;
    end else if ((state_q == TRK_BUSY) && back_idle) begin
      state_d = TRK_IDLE;
      code_d  = IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TRK_IDLE;
      code_q  <= IDLE;
      ale_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      ale_q   <= start_p;
    end
  end

  assign busy_q = (state_q == TRK_BUSY);
endmodule

// File: rtl/bcsd_cmd_decoder.sv
module bcsd_cmd_decoder #(
  parameter int ST_W  = bcsd_pkg::ST_W,
  parameter int N_CMD = bcsd_pkg::N_CMD
) (
  input  logic             busy,
  input  logic [ST_W-1:0]  code,
  output logic [N_CMD-1:0] strobe_vec
);
  // one strobe per non-idle code, indexed by the code value
  for (genvar i = 0; i < N_CMD; i++) begin : g_stb
    assign strobe_vec[i] = busy && (code == ST_W'(i));
  end
endmodule

// File: rtl/bus_cycle_decoder.sv
module bus_cycle_decoder (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] st_in,
  input  logic [2:0] phase,
  input  logic       rdy,
  input  logic       grant_act,
  output logic       ale,
  output logic       int_ack,
  output logic       rd_io,
  output logic       wr_io,
  output logic       halt_ind,
  output logic       fetch,
  output logic       rd_mem,
  output logic       wr_mem,
  output logic [2:0] cyc_code
);
  import bcsd_pkg::*;

  logic [ST_W-1:0]  st_eff;
  logic             leave_idle;
  logic             back_idle;
  logic             busy_q;
  logic [ST_W-1:0]  code_q;
  logic [N_CMD-1:0] strobe_vec;

  bcsd_status_sampler #(.ST_W(ST_W), .PH_W(PH_W)) u_smp (
    .clk        (clk),
    .rst        (rst),
    .st_in      (st_in),
    .phase      (phase),
    .rdy        (rdy),
    .grant_act  (grant_act),
    .st_eff     (st_eff),
    .leave_idle (leave_idle),
    .back_idle  (back_idle)
  );

  bcsd_cycle_tracker #(.ST_W(ST_W)) u_trk (
    .clk        (clk),
    .rst        (rst),
    .grant_act  (grant_act),
    .st_eff     (st_eff),
    .leave_idle (leave_idle),
    .back_idle  (back_idle),
    .busy_q     (busy_q),
    .code_q     (code_q),
    .ale_q      (ale)
  );

  bcsd_cmd_decoder #(.ST_W(ST_W), .N_CMD(N_CMD)) u_dec (
    .busy       (busy_q),
    .code       (code_q),
    .strobe_vec (strobe_vec)
  );

  assign int_ack  = strobe_vec[ST_INTA];
  assign rd_io    = strobe_vec[ST_IORD];
  assign wr_io    = strobe_vec[ST_IOWR];
  assign halt_ind = strobe_vec[ST_HALT];
  assign fetch    = strobe_vec[ST_CODE];
  assign rd_mem   = strobe_vec[ST_MRD];
  assign wr_mem   = strobe_vec[ST_MWR];
  assign cyc_code = code_q;
endmodule

// File: rtl/bcsd_checker.sv
module bcsd_checker #(
  parameter int ST_W  = bcsd_pkg::ST_W,
  parameter int PH_W  = bcsd_pkg::PH_W,
  parameter int N_CMD = bcsd_pkg::N_CMD
) (
  input logic             clk,
  input logic             rst,
  input logic [ST_W-1:0]  st_in,
  input logic [PH_W-1:0]  phase,
  input logic             rdy,
  input logic             grant_act,
  input logic             ale,
  input logic [N_CMD-1:0] strobe_vec,
  input logic [ST_W-1:0]  cyc_code
);
  localparam logic [PH_W-1:0] P_T1 = PH_W'(bcsd_pkg::PH_T1);
  localparam logic [PH_W-1:0] P_T2 = PH_W'(bcsd_pkg::PH_T2);
  localparam logic [PH_W-1:0] P_T3 = PH_W'(bcsd_pkg::PH_T3);
  localparam logic [PH_W-1:0] P_TW = PH_W'(bcsd_pkg::PH_TW);

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe_vec)); // R8
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
    (strobe_vec == '0) |-> (cyc_code == '1)); // R1
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale); // R3
  AST_ALE_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    ale |-> (strobe_vec != '0)); // R3
  AST_CLOSE_IN_T3: assert property (@(posedge clk) disable iff (rst)
    ((strobe_vec != '0) && !grant_act && (st_in == '1) && (phase == P_T3))
      |=> (strobe_vec == '0)); // R4
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((strobe_vec != '0) && !grant_act && (phase == P_TW) && !rdy)
      |=> ((strobe_vec != '0) && $stable(cyc_code))); // R4
  AST_MID_STABLE: assert property (@(posedge clk) disable iff (rst)
    ((strobe_vec != '0) && !grant_act && ((phase == P_T1) || (phase == P_T2)))
      |=> $stable(cyc_code)); // R5
  AST_NO_LATE_OPEN: assert property (@(posedge clk) disable iff (rst)
    ((strobe_vec == '0) && ((phase == P_T2) || (phase == P_T3) || (phase == P_TW)))
      |=> !ale); // R6
  AST_GRANT_QUIET: assert property (@(posedge clk) disable iff (rst)
    grant_act |=> ((strobe_vec == '0) && !ale)); // R7
endmodule

bind bus_cycle_decoder bcsd_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .st_in      (st_in),
  .phase      (phase),
  .rdy        (rdy),
  .grant_act  (grant_act),
  .ale        (ale),
  .strobe_vec (strobe_vec),
  .cyc_code   (cyc_code)
);

// File: tb/tb_bus_cycle_decoder.sv
module tb_bus_cycle_decoder;
  localparam logic [2:0] T1 = 3'd0, T2 = 3'd1, T3 = 3'd2, TW = 3'd3, T4 = 3'd4, TI = 3'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] st_in = 3'b111;
  logic [2:0] phase = TI;
  logic rdy = 1'b0;
  logic grant_act = 1'b0;
  logic ale, int_ack, rd_io, wr_io, halt_ind, fetch, rd_mem, wr_mem;
  logic [2:0] cyc_code;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  bus_cycle_decoder dut (
    .clk(clk), .rst(rst), .st_in(st_in), .phase(phase), .rdy(rdy),
    .grant_act(grant_act), .ale(ale), .int_ack(int_ack), .rd_io(rd_io),
    .wr_io(wr_io), .halt_ind(halt_ind), .fetch(fetch), .rd_mem(rd_mem),
    .wr_mem(wr_mem), .cyc_code(cyc_code)
  );

  function automatic logic [6:0] stb_of(input logic [2:0] c);
    return (c == 3'b111) ? 7'd0 : 7'(1 << c);
  endfunction

  // drive one clock of inputs; expected outputs refer to the state after the next edge
  task automatic drive(input logic r, input logic [2:0] st, input logic [2:0] ph,
                       input logic rd, input logic g, input logic e_ale,
                       input logic [2:0] e_code, input string tag);
    @(negedge clk);
    rst = r; st_in = st; phase = ph; rdy = rd; grant_act = g;
    exp_q.push_back({e_ale, stb_of(e_code), e_code});
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expected item per edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [10:0] e;
      logic [10:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {ale, wr_mem, rd_mem, fetch, halt_ind, wr_io, rd_io, int_ack, cyc_code};
      n_run++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s actual ale=%b stb=%b code=%b expected ale=%b stb=%b code=%b",
                 t, a[10], a[9:3], a[2:0], e[10], e[9:3], e[2:0]);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    drive(1, 3'b101, T4, 0, 0, 0, 3'b111, "R9 reset with code present");
    drive(1, 3'b000, T1, 0, 0, 0, 3'b111, "R9 reset held");
    // R2 R3 memory read opening in T4, closing in T3
    drive(0, 3'b101, T4, 0, 0, 1, 3'b101, "R2 open mem read");
    drive(0, 3'b101, T1, 0, 0, 0, 3'b101, "R3 ale single clock");
    drive(0, 3'b101, T2, 0, 0, 0, 3'b101, "R1 mem read held");
    drive(0, 3'b111, T3, 0, 0, 0, 3'b111, "R4 close in T3");
    // R4 wait states on an I/O read
    drive(0, 3'b001, T4, 0, 0, 1, 3'b001, "R2 back-to-back io read");
    drive(0, 3'b001, T1, 0, 0, 0, 3'b001, "R1 io read");
    drive(0, 3'b001, T3, 0, 0, 0, 3'b001, "R4 non-idle in T3 keeps open");
    drive(0, 3'b111, TW, 0, 0, 0, 3'b001, "R4 Tw without ready keeps open");
    drive(0, 3'b111, TW, 1, 0, 0, 3'b111, "R4 Tw with ready closes");
    // R5 idle in T1 and code change do not disturb
    drive(0, 3'b100, T4, 0, 0, 1, 3'b100, "R2 open code fetch");
    drive(0, 3'b111, T1, 0, 0, 0, 3'b100, "R5 idle in T1 no close");
    drive(0, 3'b110, T2, 0, 0, 0, 3'b100, "R5 code change ignored");
    drive(0, 3'b111, T4, 0, 0, 0, 3'b100, "R5 idle in T4 no close");
    drive(0, 3'b111, T3, 0, 0, 0, 3'b111, "R4 fetch closes");
    // R6 leaving idle in wrong states
    drive(0, 3'b110, T2, 0, 0, 0, 3'b111, "R6 no open in T2");
    drive(0, 3'b110, T4, 0, 0, 0, 3'b111, "R6 prior sample not idle");
    drive(0, 3'b111, T3, 0, 0, 0, 3'b111, "R6 back to idle");
    drive(0, 3'b110, TW, 1, 0, 0, 3'b111, "R6 no open in Tw");
    drive(0, 3'b111, TI, 0, 0, 0, 3'b111, "R6 idle state");
    drive(0, 3'b010, TI, 0, 0, 0, 3'b111, "R6 no open in idle state");
    drive(0, 3'b111, TI, 0, 0, 0, 3'b111, "R6 idle again");
    drive(0, 3'b010, T1, 0, 0, 1, 3'b010, "R2 open io write in T1");
    drive(0, 3'b010, T2, 0, 0, 0, 3'b010, "R1 io write");
    drive(0, 3'b111, T3, 0, 0, 0, 3'b111, "R4 io write closes");
    // R8 halt
    drive(0, 3'b011, T4, 0, 0, 1, 3'b011, "R8 halt only");
    drive(0, 3'b011, T1, 0, 0, 0, 3'b011, "R8 halt held");
    drive(0, 3'b111, T3, 0, 0, 0, 3'b111, "R4 halt closes");
    // R7 grant masking and abort
    drive(0, 3'b000, T4, 0, 1, 0, 3'b111, "R7 grant masks T4 code");
    drive(0, 3'b111, TI, 0, 1, 0, 3'b111, "R7 grant float high");
    drive(0, 3'b000, T1, 0, 1, 0, 3'b111, "R7 grant masks T1 code");
    drive(0, 3'b111, TI, 0, 0, 0, 3'b111, "R7 grant released");
    drive(0, 3'b000, T4, 0, 0, 1, 3'b000, "R1 open interrupt ack");
    drive(0, 3'b000, T1, 0, 0, 0, 3'b000, "R1 interrupt ack held");
    drive(0, 3'b111, T2, 0, 1, 0, 3'b111, "R7 grant drops open cycle");
    drive(0, 3'b111, TI, 0, 0, 0, 3'b111, "R7 idle after grant");
    // remaining codes
    drive(0, 3'b110, T4, 0, 0, 1, 3'b110, "R1 open mem write");
    drive(0, 3'b111, T3, 0, 0, 0, 3'b111, "R4 mem write closes");
    drive(0, 3'b010, T4, 0, 0, 1, 3'b010, "R2 open after T3 close");
    drive(0, 3'b111, TW, 1, 0, 0, 3'b111, "R4 Tw ready close");
    // R9 reset in mid-transfer
    drive(0, 3'b101, T4, 0, 0, 1, 3'b101, "R2 open before reset");
    drive(1, 3'b101, T1, 0, 0, 0, 3'b111, "R9 reset clears open cycle");
    drive(0, 3'b101, T4, 0, 0, 1, 3'b101, "R9 sample after reset counts idle");
    drive(0, 3'b111, T3, 0, 0, 0, 3'b111, "R4 final close");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule